// File: doc/BRIEF.md
# I/Q Sample Capture with Offset Trim

This block takes 16-bit samples from a parallel input bus that is timed by a separate data clock. It sorts the samples into an in-phase (I) and a quadrature (Q) channel. Samples arrive in one of two ways. In single-bus mode, I and Q words share bus A, and a channel-select pin tags each word. In two-bus mode, I arrives on bus A and Q on bus B in the same data-clock cycle. Configuration inputs choose which data-clock transition captures a word. They also choose whether the incoming words are offset binary or two's complement.

After capture, each channel has its own trim applied: a 10-bit magnitude multiplied by four, added or subtracted as set by a direction bit. The sum saturates at the 16-bit signed limits. Results come out as aligned I/Q pairs with a one-cycle valid strobe. The trim and format settings for a pair are sampled in the cycle that completes the pair, so a pair never mixes two settings.

The data clock and the bus are oversampled by the block's own clock. That clock must run at least four times faster than the data clock. Reset is asserted asynchronously and released synchronously inside the block.

Top module: `iq_capture_top`

## Requirements
- R1: While reset is asserted, and after release until the first pair, out_valid is 0 and out_i and out_q are 0.
- R2: With cfg_fall_edge = 0, a low-to-high transition of dclk captures a word and a high-to-low transition captures nothing. With cfg_fall_edge = 1, the roles of the two transitions swap.
- R3: With cfg_dual_port = 1, every capturing dclk transition produces one pair: I from bus_a and Q from bus_b. The dclk transition and the bus are sampled on the same clk edge, and out_valid is high for exactly one cycle, starting on the second clk edge after that one.
- R4: With cfg_dual_port = 0, a word on bus_a goes to I when sel_i = 1 and to Q when sel_i = 0. A pair is emitted only once both an I word and a Q word are held, in either order. After that, both channels count as empty again.
- R5: In single-bus mode, a second word for a channel that has not yet been paired replaces the earlier word for that channel.
- R6: cfg_offset_bin = 1 inverts bit 15 of each captured word, which converts offset binary to two's complement. cfg_offset_bin = 0 leaves the word unchanged.
- R7: Each output is the converted word plus 4 × magnitude when the channel's direction bit is 0, and minus 4 × magnitude when it is 1. This gives ±4092 in steps of 4.
- R8: A sum above +32767 gives 0x7FFF, and a sum below −32768 gives 0x8000. Sums never wrap.
- R9: The trim and format settings used for a pair are those present in the cycle in which the pair completes. Changes made one cycle later affect only the following pairs.
- R10: bus_b has no effect in single-bus mode, and sel_i has no effect in two-bus mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; oversamples the data clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_offset_bin | input | 1 | 1: input words are offset binary |
| cfg_dual_port | input | 1 | 1: two-bus mode, 0: single-bus interleaved |
| cfg_fall_edge | input | 1 | 1: capture on the falling dclk edge |
| cfg_ofs_mag_i | input | 10 | I trim magnitude |
| cfg_ofs_neg_i | input | 1 | I trim direction, 1 subtracts |
| cfg_ofs_mag_q | input | 10 | Q trim magnitude |
| cfg_ofs_neg_q | input | 1 | Q trim direction, 1 subtracts |
| dclk | input | 1 | Data clock |
| sel_i | input | 1 | Single-bus channel tag, 1 = I |
| bus_a | input | 16 | Sample bus A |
| bus_b | input | 16 | Sample bus B (Q in two-bus mode) |
| out_i | output | 16 | I result, two's complement |
| out_q | output | 16 | Q result, two's complement |
| out_valid | output | 1 | One-cycle strobe for an aligned pair |

## Verification
The assertions assume the following about the inputs:
- dclk, the buses and sel_i change in step with clk.
- Each dclk level lasts at least two clk cycles, so out_valid never asserts on two cycles in a row.
- cfg_fall_edge does not change while dclk is changing.
- The data bus holds its value from the capturing transition until the word has been sampled.

The stimulus meets all of these. It drives every input on the falling clk edge and holds each dclk level for three clk cycles. It changes the edge polarity only while dclk is idle, and it orders that change so the idle-level move is itself the non-capturing transition.

// File: rtl/iq_cap_pkg.sv
package iq_cap_pkg;
  // channel tag carried by the select pin in single-bus mode
  typedef enum logic {
    CH_Q = 1'b0,
    CH_I = 1'b1
  } iq_chan_e;

  // which channels hold an unpaired word
  typedef struct packed {
    logic have_i;
    logic have_q;
  } iq_pend_t;
endpackage

// File: rtl/iq_rst_sync.sv
module iq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/iq_edge_sampler.sv
module iq_edge_sampler #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fall_edge,
  input  logic              dclk,
  input  logic              sel_in,
  input  logic [DATA_W-1:0] bus_a,
  input  logic [DATA_W-1:0] bus_b,
  output logic              cap_stb,
  output logic              cap_sel,
  output logic [DATA_W-1:0] cap_a,
  output logic [DATA_W-1:0] cap_b
);
  logic              dclk_q, dclk_qq;
  logic              sel_q;
  logic [DATA_W-1:0] a_q, b_q;
  logic              rise_seen, fall_seen;

  // bus and data clock sampled together so a word stays aligned with its edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dclk_q  <= 1'b0;
      dclk_qq <= 1'b0;
      sel_q   <= 1'b0;
      a_q     <= '0;
      b_q     <= '0;
    end else begin
      dclk_q  <= dclk;
      dclk_qq <= dclk_q;
      sel_q   <= sel_in;
      a_q     <= bus_a;
      b_q     <= bus_b;
    end
  end

  always_comb begin
    rise_seen = dclk_q & ~dclk_qq;
    fall_seen = ~dclk_q & dclk_qq;
    cap_stb   = fall_edge ? fall_seen : rise_seen;
  end

  assign cap_sel = sel_q;
  assign cap_a   = a_q;
  assign cap_b   = b_q;
endmodule

// File: rtl/iq_pair_steer.sv
module iq_pair_steer
  import iq_cap_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dual_port,
  input  logic              cap_stb,
  input  logic              cap_sel,
  input  logic [DATA_W-1:0] cap_a,
  input  logic [DATA_W-1:0] cap_b,
  output logic              pair_fire,
  output logic              pair_v,
  output logic [DATA_W-1:0] pair_i,
  output logic [DATA_W-1:0] pair_q
);
  iq_pend_t          pend_q, pend_d;
  logic [DATA_W-1:0] hold_i_q, hold_i_d;
  logic [DATA_W-1:0] hold_q_q, hold_q_d;
  logic [DATA_W-1:0] pair_i_q, pair_i_d;
  logic [DATA_W-1:0] pair_q_q, pair_q_d;
  logic              pair_v_q;
  logic              fire;

  always_comb begin
    pend_d   = pend_q;
    hold_i_d = hold_i_q;
    hold_q_d = hold_q_q;
    pair_i_d = pair_i_q;
    pair_q_d = pair_q_q;
    fire     = 1'b0;
    if (dual_port) begin
      pend_d = '0;
      if (cap_stb) begin
        fire     = 1'b1;
        pair_i_d = cap_a;
        pair_q_d = cap_b;
      end
    end else if (cap_stb) begin
      if (iq_chan_e'(cap_sel) == CH_I) begin
        hold_i_d      = cap_a;
        pend_d.have_i = 1'b1;
      end else begin
        hold_q_d      = cap_a;
        pend_d.have_q = 1'b1;
      end
      if (pend_d.have_i && pend_d.have_q) begin
        fire     = 1'b1;
        pair_i_d = hold_i_d;
        pair_q_d = hold_q_d;
        pend_d   = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q   <= '0;
      hold_i_q <= '0;
      hold_q_q <= '0;
      pair_i_q <= '0;
      pair_q_q <= '0;
      pair_v_q <= 1'b0;
    end else begin
      pend_q   <= pend_d;
      hold_i_q <= hold_i_d;
      hold_q_q <= hold_q_d;
      pair_i_q <= pair_i_d;
      pair_q_q <= pair_q_d;
      pair_v_q <= fire;
    end
  end

  assign pair_fire = fire;
  assign pair_v    = pair_v_q;
  assign pair_i    = pair_i_q;
  assign pair_q    = pair_q_q;
endmodule

// File: rtl/iq_ofs_lane.sv
module iq_ofs_lane #(
  parameter int DATA_W    = 16,
  parameter int OFS_W     = 10,
  parameter int OFS_SHIFT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              offset_bin,
  input  logic              ofs_neg,
  input  logic [OFS_W-1:0]  ofs_mag,
  input  logic [DATA_W-1:0] word,
  output logic [DATA_W-1:0] result
);
  localparam int SUM_W = DATA_W + 2;
  localparam int PAD_W = SUM_W - OFS_W - OFS_SHIFT;
  localparam logic [DATA_W-1:0] POS_LIM = {1'b0, {(DATA_W-1){1'b1}}};
  localparam logic [DATA_W-1:0] NEG_LIM = {1'b1, {(DATA_W-1){1'b0}}};

  logic [DATA_W-1:0] conv;
  logic [SUM_W-1:0]  word_x, ofs_u, ofs_x, sum;
  logic [DATA_W-1:0] res_d, res_q;
  logic              in_range;

  always_comb begin
    conv             = word;
    conv[DATA_W-1]   = word[DATA_W-1] ^ offset_bin;
    word_x           = {{2{conv[DATA_W-1]}}, conv};
    ofs_u            = {{PAD_W{1'b0}}, ofs_mag, {OFS_SHIFT{1'b0}}};
    ofs_x            = ofs_neg ? (~ofs_u + SUM_W'(1)) : ofs_u;
    sum              = word_x + ofs_x;
    in_range         = (&sum[SUM_W-1:DATA_W-1]) | ~(|sum[SUM_W-1:DATA_W-1]);
    if (in_range)          res_d = sum[DATA_W-1:0];
    else if (sum[SUM_W-1]) res_d = NEG_LIM;
    else                   res_d = POS_LIM;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    res_q <= '0;
    else if (load) res_q <= res_d;
  end

  assign result = res_q;
endmodule

// File: rtl/iq_capture_top.sv
module iq_capture_top #(
  parameter int DATA_W    = 16,
  parameter int OFS_W     = 10,
  parameter int OFS_SHIFT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_offset_bin,
  input  logic              cfg_dual_port,
  input  logic              cfg_fall_edge,
  input  logic [OFS_W-1:0]  cfg_ofs_mag_i,
  input  logic              cfg_ofs_neg_i,
  input  logic [OFS_W-1:0]  cfg_ofs_mag_q,
  input  logic              cfg_ofs_neg_q,
  input  logic              dclk,
  input  logic              sel_i,
  input  logic [DATA_W-1:0] bus_a,
  input  logic [DATA_W-1:0] bus_b,
  output logic [DATA_W-1:0] out_i,
  output logic [DATA_W-1:0] out_q,
  output logic              out_valid
);
  localparam int LANES = 2;

  logic              rst_int_n;
  logic              cap_stb, cap_sel;
  logic [DATA_W-1:0] cap_a, cap_b;
  logic              pair_fire, pair_v;
  logic [DATA_W-1:0] pair_i, pair_q;

  logic [LANES-1:0][OFS_W-1:0]  cfg_mag;
  logic [LANES-1:0]             cfg_neg;
  logic [LANES-1:0][OFS_W-1:0]  snap_mag_q;
  logic [LANES-1:0]             snap_neg_q;
  logic                         snap_fmt_q;
  logic [LANES-1:0][DATA_W-1:0] lane_in, lane_out;
  logic                         out_v_q;

  assign cfg_mag = {cfg_ofs_mag_q, cfg_ofs_mag_i};
  assign cfg_neg = {cfg_ofs_neg_q, cfg_ofs_neg_i};
  assign lane_in = {pair_q, pair_i};

  iq_rst_sync #(.STAGES(2)) rst_sync_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  iq_edge_sampler #(.DATA_W(DATA_W)) sampler_i (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .fall_edge (cfg_fall_edge),
    .dclk      (dclk),
    .sel_in    (sel_i),
    .bus_a     (bus_a),
    .bus_b     (bus_b),
    .cap_stb   (cap_stb),
    .cap_sel   (cap_sel),
    .cap_a     (cap_a),
    .cap_b     (cap_b)
  );

  iq_pair_steer #(.DATA_W(DATA_W)) steer_i (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .dual_port (cfg_dual_port),
    .cap_stb   (cap_stb),
    .cap_sel   (cap_sel),
    .cap_a     (cap_a),
    .cap_b     (cap_b),
    .pair_fire (pair_fire),
    .pair_v    (pair_v),
    .pair_i    (pair_i),
    .pair_q    (pair_q)
  );

  // settings frozen in the cycle a pair completes
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      snap_mag_q <= '0;
      snap_neg_q <= '0;
      snap_fmt_q <= 1'b0;
    end else if (pair_fire) begin
      snap_mag_q <= cfg_mag;
      snap_neg_q <= cfg_neg;
      snap_fmt_q <= cfg_offset_bin;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    iq_ofs_lane #(
      .DATA_W    (DATA_W),
      .OFS_W     (OFS_W),
      .OFS_SHIFT (OFS_SHIFT)
    ) lane_i (
      .clk        (clk),
      .rst_n      (rst_int_n),
      .load       (pair_v),
      .offset_bin (snap_fmt_q),
      .ofs_neg    (snap_neg_q[g]),
      .ofs_mag    (snap_mag_q[g]),
      .word       (lane_in[g]),
      .result     (lane_out[g])
    );
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) out_v_q <= 1'b0;
    else            out_v_q <= pair_v;
  end

  assign out_i     = lane_out[0];
  assign out_q     = lane_out[1];
  assign out_valid = out_v_q;
endmodule

// File: rtl/iq_capture_chk.sv
module iq_capture_chk #(
  parameter int DATA_W = 16,
  parameter int OFS_W  = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_offset_bin,
  input logic              cfg_dual_port,
  input logic              cfg_fall_edge,
  input logic [OFS_W-1:0]  cfg_ofs_mag_i,
  input logic [OFS_W-1:0]  cfg_ofs_mag_q,
  input logic              dclk,
  input logic [DATA_W-1:0] bus_a,
  input logic [DATA_W-1:0] bus_b,
  input logic [DATA_W-1:0] out_i,
  input logic [DATA_W-1:0] out_q,
  input logic              out_valid
);
  // R1
  rst_quiet_chk: assert property (@(posedge clk)
    !rst_n |-> (!out_valid && out_i == '0 && out_q == '0));

  // R3
  one_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  // R2
  edge_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ($past(cfg_fall_edge, 2) ?
                   (!$past(dclk, 3) && $past(dclk, 4)) :
                   ($past(dclk, 3) && !$past(dclk, 4))));

  // R3
  dual_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(cfg_dual_port, 2) && !$past(cfg_offset_bin, 2) &&
     $past(cfg_ofs_mag_i, 2) == '0 && $past(cfg_ofs_mag_q, 2) == '0)
    |-> (out_i == $past(bus_a, 3) && out_q == $past(bus_b, 3)));

  // R6
  fmt_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(cfg_dual_port, 2) && $past(cfg_offset_bin, 2) &&
     $past(cfg_ofs_mag_i, 2) == '0)
    |-> (out_i == ($past(bus_a, 3) ^ {1'b1, {(DATA_W-1){1'b0}}})));
endmodule

bind iq_capture_top iq_capture_chk #(.DATA_W(DATA_W), .OFS_W(OFS_W)) chk_i (.*);

// File: tb/iq_capture_top_tb_top.sv
module iq_capture_top_tb_top;
  logic        clk;
  logic        rst_n;
  logic        cfg_offset_bin, cfg_dual_port, cfg_fall_edge;
  logic [9:0]  cfg_ofs_mag_i, cfg_ofs_mag_q;
  logic        cfg_ofs_neg_i, cfg_ofs_neg_q;
  logic        dclk, sel_i;
  logic [15:0] bus_a, bus_b;
  logic [15:0] out_i, out_q;
  logic        out_valid;

  int          errors = 0;
  int          checks = 0;
  int          vcount = 0;
  logic [15:0] last_i = '0;
  logic [15:0] last_q = '0;

  iq_capture_top dut_i (
    .clk(clk), .rst_n(rst_n),
    .cfg_offset_bin(cfg_offset_bin), .cfg_dual_port(cfg_dual_port),
    .cfg_fall_edge(cfg_fall_edge),
    .cfg_ofs_mag_i(cfg_ofs_mag_i), .cfg_ofs_neg_i(cfg_ofs_neg_i),
    .cfg_ofs_mag_q(cfg_ofs_mag_q), .cfg_ofs_neg_q(cfg_ofs_neg_q),
    .dclk(dclk), .sel_i(sel_i), .bus_a(bus_a), .bus_b(bus_b),
    .out_i(out_i), .out_q(out_q), .out_valid(out_valid)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  always @(negedge clk) begin
    if (out_valid) begin
      vcount <= vcount + 1;
      last_i <= out_i;
      last_q <= out_q;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] expect_val(input logic [15:0] w, input logic fmt,
                                             input logic neg, input int mag);
    int v;
    v = $signed(fmt ? {~w[15], w[14:0]} : w);
    v = neg ? v - 4 * mag : v + 4 * mag;
    if (v > 32767)  v = 32767;
    if (v < -32768) v = -32768;
    return 16'(v);
  endfunction

  task automatic pulse(input logic [15:0] a, input logic [15:0] b, input logic s);
    logic act;
    act = ~cfg_fall_edge;
    @(negedge clk);
    bus_a = a; bus_b = b; sel_i = s; dclk = act;
    repeat (3) @(negedge clk);
    dclk = ~act;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 valid in reset", 32'(out_valid), 32'd0);
    chk("R1 out_i in reset", 32'(out_i), 32'd0);
    @(negedge clk) rst_n = 1'b1;
    repeat (6) @(negedge clk);
    chk("R1 valid after release", 32'(out_valid), 32'd0);
    chk("R1 out_q after release", 32'(out_q), 32'd0);
    chk("R1 no pairs", 32'(vcount), 32'd0);
  endtask

  task automatic t_dual();
    int n0;
    cfg_dual_port = 1'b1;
    repeat (2) @(negedge clk);
    n0 = vcount;
    @(negedge clk);
    bus_a = 16'h1234; bus_b = 16'hABCD; sel_i = 1'b0; dclk = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R3 not yet valid", 32'(out_valid), 32'd0);
    @(negedge clk);
    chk("R3 valid on time", 32'(out_valid), 32'd1);
    chk("R3 I from bus_a", 32'(out_i), 32'h1234);
    chk("R3 Q from bus_b", 32'(out_q), 32'hABCD);
    @(negedge clk);
    chk("R3 one-cycle strobe", 32'(out_valid), 32'd0);
    dclk = 1'b0;
    repeat (3) @(negedge clk);
    chk("R2 falling edge ignored", 32'(vcount), 32'(n0 + 1));
    pulse(16'h8001, 16'h7FFE, 1'b1);
    chk("R10 sel ignored in dual I", 32'(last_i), 32'h8001);
    chk("R10 sel ignored in dual Q", 32'(last_q), 32'h7FFE);
    chk("R3 pair per edge", 32'(vcount), 32'(n0 + 2));
  endtask

  task automatic t_single();
    int n0;
    cfg_dual_port = 1'b0;
    repeat (2) @(negedge clk);
    n0 = vcount;
    pulse(16'h0111, 16'hFFFF, 1'b1);
    chk("R4 no pair after I only", 32'(vcount), 32'(n0));
    pulse(16'h0222, 16'h5555, 1'b0);
    chk("R4 pair after Q", 32'(vcount), 32'(n0 + 1));
    chk("R4 I word", 32'(last_i), 32'h0111);
    chk("R10 bus_b ignored Q", 32'(last_q), 32'h0222);
    pulse(16'h0333, 16'h0, 1'b0);
    chk("R4 flags cleared", 32'(vcount), 32'(n0 + 1));
    pulse(16'h0444, 16'h0, 1'b1);
    chk("R4 Q then I pair", 32'(vcount), 32'(n0 + 2));
    chk("R4 I of reversed pair", 32'(last_i), 32'h0444);
    chk("R4 Q of reversed pair", 32'(last_q), 32'h0333);
  endtask

  task automatic t_repeat();
    int n0;
    n0 = vcount;
    pulse(16'h0AAA, 16'h0, 1'b1);
    pulse(16'h0BBB, 16'h0, 1'b1);
    chk("R5 no pair on repeat", 32'(vcount), 32'(n0));
    pulse(16'h0CCC, 16'h0, 1'b0);
    chk("R5 newer I kept", 32'(last_i), 32'h0BBB);
    chk("R5 Q paired", 32'(last_q), 32'h0CCC);
  endtask

  task automatic t_edge();
    int n0;
    cfg_dual_port = 1'b1;
    @(negedge clk) cfg_fall_edge = 1'b1;
    n0 = vcount;
    @(negedge clk) dclk = 1'b1;
    repeat (4) @(negedge clk);
    chk("R2 rising ignored in fall mode", 32'(vcount), 32'(n0));
    pulse(16'h2468, 16'h1357, 1'b0);
    chk("R2 falling captures", 32'(vcount), 32'(n0 + 1));
    chk("R2 falling data", 32'(last_i), 32'h2468);
    @(negedge clk) cfg_fall_edge = 1'b0;
    @(negedge clk) dclk = 1'b0;
    repeat (4) @(negedge clk);
    chk("R2 falling ignored in rise mode", 32'(vcount), 32'(n0 + 1));
  endtask

  task automatic t_format();
    cfg_offset_bin = 1'b1;
    pulse(16'h0000, 16'hFFFF, 1'b0);
    chk("R6 zero code to min", 32'(last_i), 32'h8000);
    chk("R6 full code to max", 32'(last_q), 32'h7FFF);
    pulse(16'h8000, 16'h8005, 1'b0);
    chk("R6 mid code to zero", 32'(last_i), 32'h0000);
    chk("R6 mid plus five", 32'(last_q), 32'h0005);
    cfg_offset_bin = 1'b0;
  endtask

  task automatic t_offset();
    cfg_ofs_mag_i = 10'd1023; cfg_ofs_neg_i = 1'b0;
    cfg_ofs_mag_q = 10'd1023; cfg_ofs_neg_q = 1'b1;
    pulse(16'd100, 16'd100, 1'b0);
    chk("R7 add 4092", 32'(last_i), 32'(expect_val(16'd100, 1'b0, 1'b0, 1023)));
    chk("R7 subtract 4092", 32'(last_q), 32'(expect_val(16'd100, 1'b0, 1'b1, 1023)));
    cfg_ofs_mag_i = 10'd3; cfg_ofs_neg_i = 1'b1;
    cfg_ofs_mag_q = 10'd5; cfg_ofs_neg_q = 1'b0;
    pulse(16'hFFF0, 16'h0000, 1'b0);
    chk("R7 small subtract", 32'(last_i), 32'(expect_val(16'hFFF0, 1'b0, 1'b1, 3)));
    chk("R7 small add", 32'(last_q), 32'h0014);
  endtask

  task automatic t_sat();
    cfg_ofs_mag_i = 10'd1023; cfg_ofs_neg_i = 1'b0;
    cfg_ofs_mag_q = 10'd1023; cfg_ofs_neg_q = 1'b1;
    pulse(16'h7F00, 16'h8100, 1'b0);
    chk("R8 clamp high", 32'(last_i), 32'h7FFF);
    chk("R8 clamp low", 32'(last_q), 32'h8000);
    pulse(16'h7003, 16'h9000, 1'b0);
    chk("R8 below limit", 32'(last_i), 32'(expect_val(16'h7003, 1'b0, 1'b0, 1023)));
    chk("R8 above limit", 32'(last_q), 32'(expect_val(16'h9000, 1'b0, 1'b1, 1023)));
  endtask

  task automatic t_snap();
    cfg_ofs_mag_i = 10'd1; cfg_ofs_neg_i = 1'b0;
    cfg_ofs_mag_q = 10'd0; cfg_ofs_neg_q = 1'b0;
    repeat (2) @(negedge clk);
    @(negedge clk);
    bus_a = 16'd10; bus_b = 16'd20; dclk = 1'b1;
    repeat (2) @(negedge clk);
    cfg_ofs_mag_i = 10'd5;
    @(negedge clk);
    chk("R9 old setting kept", 32'(out_i), 32'd14);
    repeat (2) @(negedge clk);
    dclk = 1'b0;
    repeat (3) @(negedge clk);
    pulse(16'd10, 16'd20, 1'b0);
    chk("R9 new setting next pair", 32'(last_i), 32'd30);
    cfg_dual_port = 1'b0;
    cfg_ofs_mag_i = 10'd0;
    pulse(16'd50, 16'd0, 1'b1);
    cfg_ofs_mag_i = 10'd7;
    pulse(16'd60, 16'd0, 1'b0);
    chk("R9 completion-time setting", 32'(last_i), 32'd78);
    chk("R9 Q word", 32'(last_q), 32'd60);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b1;
    cfg_offset_bin = 1'b0; cfg_dual_port = 1'b0; cfg_fall_edge = 1'b0;
    cfg_ofs_mag_i = '0; cfg_ofs_neg_i = 1'b0;
    cfg_ofs_mag_q = '0; cfg_ofs_neg_q = 1'b0;
    dclk = 1'b0; sel_i = 1'b0; bus_a = '0; bus_b = '0;
    #1 rst_n = 1'b0;
    repeat (5) @(negedge clk);
    t_reset();
    t_dual();
    t_single();
    t_repeat();
    t_edge();
    t_format();
    t_offset();
    t_sat();
    t_snap();
    repeat (5) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule